// File: doc/BRIEF.md
# Three-Channel Gated Pulse Counter

This block counts pulses on three independent signal lines, called X, Y and Z, over a measurement window that one shared gate input defines. Each channel keeps its own binary total, 32 bits wide by default. The signal lines and the gate are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and a channel counts only the rising edges that arrive while the synchronized gate is high. Because the gate and the signals go through the same synchronizer depth, they stay aligned in time.

A host runs one measurement like this. It sets the gate period and pulses the reset so that the counters start from zero. It opens the gate for the window and then closes it. After the gate closes, the totals stay frozen. The host then reads the totals back one byte at a time. It places a channel number on `chan_sel` and a byte number on `byte_sel`, and it picks up the byte on `rd_data`. It puts the four bytes of each channel back together into one word.

The readout is a plain addressed register read with no latency. It has no valid/ready handshake, because the host controls the address and no data moves unless the host asks for it. The same applies to the pulse inputs, which are free-running level signals with no flow control.

Top module: `tri_gated_counter`

## Requirements
- R1: Each channel counts only the rising edges on its own input line (bit 0 = X, bit 1 = Y, bit 2 = Z). Edges on one line never change the totals of the other two channels.
- R2: An edge is counted only while the gate is high. Edges that arrive while the gate is low leave every total unchanged.
- R3: Holding `rst` high at a clock edge clears all three totals to zero. This applies at power-up and also in the middle of a measurement.
- R4: Byte address 0 returns bits 7:0 of the selected total, 1 returns bits 15:8, 2 returns bits 23:16 and 3 returns bits 31:24. When the counter is narrower than 32 bits, a byte address above its top byte returns zero.
- R5: Channel address 0 selects X, 1 selects Y and 2 selects Z. Channel address 3 returns zero for every byte address.
- R6: Once the gate is low, the totals hold their value. Repeated reads give the same bytes even if pulses keep arriving.
- R7: A total wraps from its all-ones value to zero on the next counted edge.
- R8: Every edge is counted, with none lost, when the input stays high for at least two clock cycles and low for at least two clock cycles. This means an input period of four clocks or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high clear of the synchronizers and totals |
| sig_in | input | 3 | Pulse inputs; bit 0 = X, bit 1 = Y, bit 2 = Z |
| gate_en | input | 1 | Shared counting window, active high, asynchronous |
| chan_sel | input | 2 | Channel to read: 0 = X, 1 = Y, 2 = Z, 3 = none |
| byte_sel | input | 2 | Byte of the selected total; 0 = least significant byte |
| rd_data | output | 8 | Selected byte, combinational from the stored totals |

## Verification
A wrong internal state shows up at `rd_data` as a wrong reassembled total once the next read happens. Because the readout has no latency, a corrupted counter can be seen in the same cycle in which it is addressed. An error in the edge detector or the gate alignment shows up as a count that is off by whole pulses. A counter that changes after the gate closes shows up as two reads of the same byte that disagree. A slip in the byte or channel decode puts the right value in the wrong lane, so the bench compares every byte of every channel, including the empty channel address.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NUM_CH = 3;
  localparam int unsigned SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    CH_X    = 2'd0,
    CH_Y    = 2'd1,
    CH_Z    = 2'd2,
    CH_NONE = 2'd3
  } chan_e;
endpackage

// File: rtl/tgc_edge_sync.sv
module tgc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  // a detected edge cannot repeat on the very next cycle
  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R8
endmodule

// File: rtl/tgc_chan_counter.sv
module tgc_chan_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + CNT_W'(1);
  end

  AST_CLEAR_ON_RST: assert property (@(posedge clk)
    rst |=> (count == '0)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(count)); // R6
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    inc |=> (count == $past(count) + CNT_W'(1))); // R7
endmodule

// File: rtl/tgc_read_mux.sv
module tgc_read_mux
  import tgc_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic [NUM_CH*CNT_W-1:0] totals,
  input  logic [SEL_W-1:0]        chan_sel,
  input  logic [SEL_W-1:0]        byte_sel,
  output logic [BYTE_W-1:0]       rd_data
);
  localparam int unsigned NBYTES = CNT_W / BYTE_W;

  logic [CNT_W-1:0] word;

  always_comb begin
    word    = '0;
    rd_data = '0;
    if (int'(chan_sel) < int'(NUM_CH))
      word = totals[int'(chan_sel)*CNT_W +: CNT_W];
    if (int'(byte_sel) < int'(NBYTES))
      rd_data = word[int'(byte_sel)*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/tri_gated_counter.sv
module tri_gated_counter
  import tgc_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        sig_in,
  input  logic              gate_en,
  input  logic [SEL_W-1:0]  chan_sel,
  input  logic [SEL_W-1:0]  byte_sel,
  output logic [BYTE_W-1:0] rd_data
);
  logic [SYNC_STAGES-1:0]  gate_sync;
  logic                    gate_open;
  logic [NUM_CH-1:0]       edge_hit;
  logic [NUM_CH-1:0]       bump;
  logic [NUM_CH*CNT_W-1:0] totals;

  // gate goes through the same depth as the signals so both line up
  always_ff @(posedge clk) begin
    if (rst) gate_sync <= '0;
    else     gate_sync <= {gate_sync[SYNC_STAGES-2:0], gate_en};
  end
  assign gate_open = gate_sync[SYNC_STAGES-1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tgc_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst    (rst),
      .din    (sig_in[c]),
      .rise_o (edge_hit[c])
    );

    assign bump[c] = edge_hit[c] & gate_open;

    tgc_chan_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (bump[c]),
      .count (totals[c*CNT_W +: CNT_W])
    );

    AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (rst)
      !gate_open |=> $stable(totals[c*CNT_W +: CNT_W])); // R2
  end

  tgc_read_mux #(.CNT_W(CNT_W)) u_mux (
    .totals   (totals),
    .chan_sel (chan_sel),
    .byte_sel (byte_sel),
    .rd_data  (rd_data)
  );

  AST_EMPTY_CHAN: assert property (@(posedge clk) disable iff (rst)
    (chan_sel == CH_NONE) |-> (rd_data == '0)); // R5
  AST_LOW_BYTE: assert property (@(posedge clk) disable iff (rst)
    (chan_sel == CH_X && byte_sel == 2'd0) |-> (rd_data == totals[BYTE_W-1:0])); // R4
endmodule

// File: tb/tri_gated_counter_tb.sv
module tri_gated_counter_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sig_in = '0;
  logic       gate_en = 1'b0;
  logic [1:0] chan_sel = '0;
  logic [1:0] byte_sel = '0;
  logic [7:0] rd_data;
  logic [7:0] rd_small;

  int errors = 0;
  int checks = 0;
  int unsigned exp_cnt [3];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_gated_counter u_dut (
    .clk(clk), .rst(rst), .sig_in(sig_in), .gate_en(gate_en),
    .chan_sel(chan_sel), .byte_sel(byte_sel), .rd_data(rd_data)
  );

  // 8-bit variant sharing all inputs, used for the wrap case
  tri_gated_counter #(.CNT_W(8)) u_wrap (
    .clk(clk), .rst(rst), .sig_in(sig_in), .gate_en(gate_en),
    .chan_sel(chan_sel), .byte_sel(byte_sel), .rd_data(rd_small)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    wait_clk(2);
    rst = 1'b0;
    for (int c = 0; c < 3; c++) exp_cnt[c] = 0;
    wait_clk(1);
  endtask

  task automatic set_gate(input logic g);
    @(negedge clk); gate_en = g;
    wait_clk(4);
  endtask

  // each pulse: two cycles high, two low
  task automatic pulse(input logic [2:0] mask, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sig_in = mask;
      wait_clk(2);
      sig_in = '0;
      wait_clk(1);
      if (gate_en)
        for (int c = 0; c < 3; c++) if (mask[c]) exp_cnt[c]++;
    end
    wait_clk(4);
  endtask

  task automatic rd(input logic [1:0] c, input logic [1:0] b, output logic [7:0] v);
    @(negedge clk); chan_sel = c; byte_sel = b;
    #1 v = rd_data;
  endtask

  task automatic rd_word(input logic [1:0] c, output logic [31:0] w);
    logic [7:0] v;
    w = '0;
    for (int b = 0; b < 4; b++) begin
      rd(c, 2'(b), v);
      w[b*8 +: 8] = v;
    end
  endtask

  task automatic check_all(input string req);
    logic [31:0] w;
    for (int c = 0; c < 3; c++) begin
      rd_word(2'(c), w);
      check(req, w, exp_cnt[c]);
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    check_all("R3 reset state");
    begin
      logic [31:0] w;
      rd_word(2'd3, w);
      check("R5 channel 3 zero", w, 32'd0);
    end
  endtask

  task automatic t_independent();
    do_reset();
    set_gate(1'b1);
    pulse(3'b001, 5);
    pulse(3'b010, 9);
    pulse(3'b100, 2);
    pulse(3'b111, 3);
    pulse(3'b101, 4);
    set_gate(1'b0);
    check_all("R1 per-channel counts");
    check("R8 X count at period 4", exp_cnt[0], 32'd12);
  endtask

  task automatic t_gate_closed();
    pulse(3'b111, 6);
    check_all("R2 edges with gate low ignored");
  endtask

  task automatic t_hold();
    logic [31:0] a, b;
    rd_word(2'd1, a);
    pulse(3'b010, 3);
    wait_clk(5);
    rd_word(2'd1, b);
    check("R6 hold after gate close", b, a);
  endtask

  task automatic t_wrap_and_bytes();
    logic [7:0] v;
    do_reset();
    set_gate(1'b1);
    pulse(3'b001, 256);
    @(negedge clk); chan_sel = 2'd0; byte_sel = 2'd0;
    #1 check("R7 8-bit wrap to zero", {24'd0, rd_small}, 32'd0);
    pulse(3'b001, 1);
    @(negedge clk); chan_sel = 2'd0; byte_sel = 2'd0;
    #1 check("R7 count after wrap", {24'd0, rd_small}, 32'd1);
    @(negedge clk); byte_sel = 2'd1;
    #1 check("R4 narrow counter upper byte zero", {24'd0, rd_small}, 32'd0);
    rd(2'd0, 2'd0, v); check("R4 byte 0 of 0x101", {24'd0, v}, 32'h01);
    rd(2'd0, 2'd1, v); check("R4 byte 1 of 0x101", {24'd0, v}, 32'h01);
    rd(2'd0, 2'd2, v); check("R4 byte 2 of 0x101", {24'd0, v}, 32'h00);
    pulse(3'b001, 44);
    rd(2'd0, 2'd0, v); check("R4 byte 0 of 0x12D", {24'd0, v}, 32'h2D);
    for (int b = 0; b < 4; b++) begin
      rd(2'd3, 2'(b), v);
      check("R5 channel 3 byte zero", {24'd0, v}, 32'd0);
    end
    set_gate(1'b0);
    check_all("R4 reassembled totals");
  endtask

  task automatic t_mid_reset();
    set_gate(1'b1);
    pulse(3'b110, 7);
    do_reset();
    check_all("R3 mid-run clear");
    pulse(3'b011, 2);
    set_gate(1'b0);
    check_all("R3 restart from zero");
  endtask

  initial begin
    t_reset_state();
    t_independent();
    t_gate_closed();
    t_hold();
    t_wrap_and_bytes();
    t_mid_reset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule